// File: doc/BRIEF.md
# Modem Status Register with Sticky Event Bits

This block holds the 16-bit status word of a half-duplex field-bus modem. The word is read and written through a plain register port. Error and event conditions arrive as one-cycle pulses and are latched into sticky bits. Software clears a sticky bit by writing 1 to its position.

The other bits are live copies of input conditions, registered once. These are carrier presence, the level, full and empty flags of the receive and transmit FIFOs, and the two jabber-inhibitor state bits. Writes do not affect them.

The block also generates clear-to-send from request-to-send. In half-duplex mode clear-to-send is held off while a carrier is present. In full-duplex mode it follows request-to-send directly. A sticky bit records that a reset has taken place, so software can tell when the modem has restarted.

Top module: `mdm_stat_reg`

## Requirements
- R1: The word layout is fixed, from bit 15 down to bit 0: reset seen, jabber off, jabber on, gap error, frame error, parity error, watchdog expired, CRC error, receive at level, receive full, receive empty, transmit at level, transmit full, transmit empty, carrier detect, clear-to-send.
- R2: A sticky bit (15, 12, 11, 10, 9, 8) becomes 1 on the clock edge where its event pulse is high. It stays 1 until a write with a 1 at that position, which clears it on that edge.
- R3: Writing 0 to a sticky bit leaves it unchanged. Writes to the live bits (14, 13, 7 to 0) have no effect on them.
- R4: When an event pulse and a write-1-to-clear hit the same sticky bit on the same edge, the bit ends at 1.
- R5: Bit 11 latches on either a frame-error pulse or a half-bit-slip pulse.
- R6: Bit 1 (carrier) and bits 7 to 2 (FIFO flags) show their inputs as sampled on the previous clock edge.
- R7: Bits 14 and 13 show the jabber-off and jabber-on inputs as sampled on the previous clock edge, and never latch.
- R8: With full-duplex low, clear-to-send (cts_o and bit 0) is 1 one edge after request-to-send is 1 while carrier is 0. Otherwise it is 0.
- R9: With full-duplex high, clear-to-send equals request-to-send from the previous edge, whatever the carrier.
- R10: While reset is high, every bit and rd_data are 0. Bit 15 reads 1 from the second edge after reset falls.
- R11: rd_data takes the status word on an edge where rd_en is high and holds it otherwise. A read changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data; a 1 clears the matching sticky bit |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| ev_gap_i | input | 1 | Gap error pulse |
| ev_frame_i | input | 1 | Frame error pulse |
| ev_slip_i | input | 1 | Half-bit slip pulse |
| ev_parity_i | input | 1 | Parity error pulse |
| ev_wdt_i | input | 1 | Watchdog expiry pulse |
| ev_crc_i | input | 1 | CRC error pulse |
| jab_on_i | input | 1 | Jabber inhibitor engaged |
| jab_off_i | input | 1 | Jabber inhibitor timeout expired |
| carrier_i | input | 1 | Valid carrier present |
| rx_lvl_i | input | 1 | Receive FIFO at programmed level |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_empty_i | input | 1 | Receive FIFO empty |
| tx_lvl_i | input | 1 | Transmit FIFO at programmed level |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| rts_i | input | 1 | Request to send |
| full_dup_i | input | 1 | Full-duplex mode select |
| cts_o | output | 1 | Clear to send |

## Verification
The assertions treat the event inputs as single-edge pulses that can arrive at any time, including during a clear write. They rely on the live inputs being sampled, never combinationally passed through. The checks on clear-to-send assume request-to-send, carrier and full-duplex are held stable around the clock edge.

The bench meets these assumptions by changing inputs only on the falling clock edge. It raises each pulse for exactly one rising edge. It also stages the one collision case, where a pulse and a clear write share an edge, on purpose.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;
  localparam int STAT_W = 16;
  // bit positions: software decodes these
  localparam int B_RST    = 15;
  localparam int B_JOFF   = 14;
  localparam int B_JON    = 13;
  localparam int B_GAP    = 12;
  localparam int B_FRAME  = 11;
  localparam int B_PAR    = 10;
  localparam int B_WDT    = 9;
  localparam int B_CRC    = 8;
  localparam int B_RXLVL  = 7;
  localparam int B_RXFULL = 6;
  localparam int B_RXEMP  = 5;
  localparam int B_TXLVL  = 4;
  localparam int B_TXFULL = 3;
  localparam int B_TXEMP  = 2;
  localparam int B_CD     = 1;
  localparam int B_CTS    = 0;
  localparam logic [STAT_W-1:0] STICKY_MASK = 16'h9F00;
  localparam logic [STAT_W-1:0] LIVE_MASK   = 16'h60FE;
endpackage

// File: rtl/mdm_stat_sticky.sv
module mdm_stat_sticky #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic unused_in;
  assign unused_in = ^((set_i | clr_i) & ~MASK);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic b_q;
      always_ff @(posedge clk) begin
        if (rst)            b_q <= 1'b0;
        else if (set_i[i])  b_q <= 1'b1;   // set wins over clear
        else if (clr_i[i])  b_q <= 1'b0;
      end
      assign q_o[i] = b_q;
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mdm_stat_live.sv
module mdm_stat_live #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] q_o
);
  logic unused_in;
  assign unused_in = ^(cond_i & ~MASK);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic b_q;
      always_ff @(posedge clk) begin
        if (rst) b_q <= 1'b0;
        else     b_q <= cond_i[i];
      end
      assign q_o[i] = b_q;
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mdm_stat_cts.sv
module mdm_stat_cts (
  input  logic clk,
  input  logic rst,
  input  logic rts_i,
  input  logic carrier_i,
  input  logic full_dup_i,
  output logic cts_o
);
  logic grant;
  always_comb begin
    if (full_dup_i) grant = rts_i;
    else            grant = rts_i & ~carrier_i;
  end

  always_ff @(posedge clk) begin
    if (rst) cts_o <= 1'b0;
    else     cts_o <= grant;
  end
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
  import mdm_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [STAT_W-1:0] rd_data,
  input  logic              ev_gap_i,
  input  logic              ev_frame_i,
  input  logic              ev_slip_i,
  input  logic              ev_parity_i,
  input  logic              ev_wdt_i,
  input  logic              ev_crc_i,
  input  logic              jab_on_i,
  input  logic              jab_off_i,
  input  logic              carrier_i,
  input  logic              rx_lvl_i,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  input  logic              tx_lvl_i,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic              rts_i,
  input  logic              full_dup_i,
  output logic              cts_o
);
  // reset-seen pulse: high on the first cycle after reset falls
  logic rst_d;
  logic rst_evt;
  always_ff @(posedge clk) begin
    if (rst) rst_d <= 1'b1;
    else     rst_d <= 1'b0;
  end
  assign rst_evt = rst_d & ~rst;

  logic [STAT_W-1:0] set_vec, clr_vec, live_vec;
  always_comb begin
    set_vec          = '0;
    set_vec[B_RST]   = rst_evt;
    set_vec[B_GAP]   = ev_gap_i;
    set_vec[B_FRAME] = ev_frame_i | ev_slip_i;
    set_vec[B_PAR]   = ev_parity_i;
    set_vec[B_WDT]   = ev_wdt_i;
    set_vec[B_CRC]   = ev_crc_i;
  end
  assign clr_vec = wr_en ? wr_data : '0;

  always_comb begin
    live_vec           = '0;
    live_vec[B_JOFF]   = jab_off_i;
    live_vec[B_JON]    = jab_on_i;
    live_vec[B_RXLVL]  = rx_lvl_i;
    live_vec[B_RXFULL] = rx_full_i;
    live_vec[B_RXEMP]  = rx_empty_i;
    live_vec[B_TXLVL]  = tx_lvl_i;
    live_vec[B_TXFULL] = tx_full_i;
    live_vec[B_TXEMP]  = tx_empty_i;
    live_vec[B_CD]     = carrier_i;
  end

  logic [STAT_W-1:0] sticky_q, live_q, status_q;
  logic              cts_q;

  mdm_stat_sticky #(.W(STAT_W), .MASK(STICKY_MASK)) u_sticky (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .q_o(sticky_q)
  );

  mdm_stat_live #(.W(STAT_W), .MASK(LIVE_MASK)) u_live (
    .clk(clk), .rst(rst), .cond_i(live_vec), .q_o(live_q)
  );

  mdm_stat_cts u_cts (
    .clk(clk), .rst(rst), .rts_i(rts_i), .carrier_i(carrier_i),
    .full_dup_i(full_dup_i), .cts_o(cts_q)
  );

  always_comb begin
    status_q        = sticky_q | live_q;
    status_q[B_CTS] = cts_q;
  end
  assign cts_o = cts_q;

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= status_q;
  end
endmodule

// File: rtl/mdm_stat_chk.sv
module mdm_stat_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        ev_gap_i,
  input logic        ev_slip_i,
  input logic        ev_parity_i,
  input logic        ev_wdt_i,
  input logic        carrier_i,
  input logic        jab_on_i,
  input logic        rts_i,
  input logic        full_dup_i,
  input logic        cts_o,
  input logic [15:0] status_q
);
  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (status_q[12] && !ev_gap_i && !(wr_en && wr_data[12])) |=> status_q[12]);
  p_w1c_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[9] && !ev_wdt_i) |=> !status_q[9]);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    ev_parity_i |=> status_q[10]);
  p_slip_frame_r5: assert property (@(posedge clk) disable iff (rst)
    ev_slip_i |=> status_q[11]);
  p_cd_live_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status_q[1] == $past(carrier_i)));
  p_jab_live_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status_q[13] == $past(jab_on_i)));
  p_cts_block_r8: assert property (@(posedge clk) disable iff (rst)
    (!full_dup_i && carrier_i) |=> !cts_o);
  p_cts_full_r9: assert property (@(posedge clk) disable iff (rst)
    full_dup_i |=> (cts_o == $past(rts_i)));
  p_rst_flag_r10: assert property (@(posedge clk)
    $fell(rst) |=> status_q[15]);
  p_rd_capture_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == $past(status_q)));
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind mdm_stat_reg mdm_stat_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_data(rd_data), .ev_gap_i(ev_gap_i), .ev_slip_i(ev_slip_i),
  .ev_parity_i(ev_parity_i), .ev_wdt_i(ev_wdt_i), .carrier_i(carrier_i),
  .jab_on_i(jab_on_i), .rts_i(rts_i), .full_dup_i(full_dup_i),
  .cts_o(cts_o), .status_q(status_q)
);

// File: tb/mdm_stat_reg_tb.sv
module mdm_stat_reg_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic ev_gap = 0, ev_frame = 0, ev_slip = 0, ev_par = 0, ev_wdt = 0, ev_crc = 0;
  logic jab_on = 0, jab_off = 0, carrier = 0;
  logic rx_lvl = 0, rx_full = 0, rx_empty = 0, tx_lvl = 0, tx_full = 0, tx_empty = 0;
  logic rts = 0, fdup = 0;
  logic cts;

  int checks = 0, errors = 0;
  bit done = 0;

  mdm_stat_reg dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ev_gap_i(ev_gap), .ev_frame_i(ev_frame),
    .ev_slip_i(ev_slip), .ev_parity_i(ev_par), .ev_wdt_i(ev_wdt),
    .ev_crc_i(ev_crc), .jab_on_i(jab_on), .jab_off_i(jab_off),
    .carrier_i(carrier), .rx_lvl_i(rx_lvl), .rx_full_i(rx_full),
    .rx_empty_i(rx_empty), .tx_lvl_i(tx_lvl), .tx_full_i(tx_full),
    .tx_empty_i(tx_empty), .rts_i(rts), .full_dup_i(fdup), .cts_o(cts)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_word(output logic [15:0] v);
    rd_en = 1; step(); rd_en = 0; v = rd_data;
  endtask

  task automatic wr_word(input logic [15:0] v);
    wr_en = 1; wr_data = v; step(); wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    rd_en = 1; step(); step(); rd_en = 0;
    chk("R10 reset zero", rd_data, 16'h0000);
    rst = 0; step(); step();
    rd_word(v); chk("R10 reset flag", v, 16'h8000);
    wr_word(16'h8000);
    rd_word(v); chk("R2 reset flag cleared", v, 16'h0000);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    ev_gap = 1; step(); ev_gap = 0; step();
    rd_word(v); chk("R2 gap latched", v, 16'h1000);
    rd_word(v); chk("R11 reread unchanged", v, 16'h1000);
    wr_word(16'h0000);
    rd_word(v); chk("R3 write zero keeps", v, 16'h1000);
    ev_wdt = 1; step(); ev_wdt = 0;
    rd_word(v); chk("R1 gap and wdt positions", v, 16'h1200);
    wr_word(16'h1000);
    rd_word(v); chk("R2 only gap cleared", v, 16'h0200);
    wr_word(16'hFFFF);
    rd_word(v); chk("R2 all cleared", v, 16'h0000);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    ev_crc = 1; wr_en = 1; wr_data = 16'h0100; step();
    ev_crc = 0; wr_en = 0; wr_data = '0;
    rd_word(v); chk("R4 set beats clear", v, 16'h0100);
    ev_par = 1; step(); ev_par = 0;
    wr_word(16'h0500);
    rd_word(v); chk("R4 later clear works", v, 16'h0000);
  endtask

  task automatic t_frame();
    logic [15:0] v;
    ev_slip = 1; step(); ev_slip = 0;
    rd_word(v); chk("R5 slip sets frame", v, 16'h0800);
    wr_word(16'h0800);
    ev_frame = 1; step(); ev_frame = 0;
    rd_word(v); chk("R5 frame sets frame", v, 16'h0800);
    wr_word(16'h0800);
  endtask

  task automatic t_live();
    logic [15:0] v;
    rx_full = 1; tx_empty = 1; carrier = 1; rx_lvl = 1; step();
    rd_word(v); chk("R6 fifo and carrier live", v, 16'h00C6);
    wr_word(16'hFFFF);
    rd_word(v); chk("R3 live bits ignore write", v, 16'h00C6);
    rx_full = 0; tx_empty = 0; carrier = 0; rx_lvl = 0;
    rx_empty = 1; tx_lvl = 1; tx_full = 1; step();
    rd_word(v); chk("R6 other fifo flags", v, 16'h0038);
    rx_empty = 0; tx_lvl = 0; tx_full = 0;
    jab_on = 1; step();
    rd_word(v); chk("R7 jabber on", v, 16'h2000);
    jab_on = 0; jab_off = 1; step();
    rd_word(v); chk("R7 jabber off not latched", v, 16'h4000);
    jab_off = 0; step();
    rd_word(v); chk("R7 jabber idle", v, 16'h0000);
  endtask

  task automatic t_cts_half();
    logic [15:0] v;
    rts = 1; @(posedge clk); #1;
    chk("R8 cts registered", {15'b0, cts}, 16'h0001);
    @(negedge clk);
    rd_word(v); chk("R8 cts bit0", v, 16'h0001);
    carrier = 1; step();
    chk("R8 carrier blocks cts", {15'b0, cts}, 16'h0000);
    carrier = 0; rts = 0; step();
    chk("R8 no rts no cts", {15'b0, cts}, 16'h0000);
  endtask

  task automatic t_cts_full();
    logic [15:0] v;
    fdup = 1; carrier = 1; rts = 1; step();
    chk("R9 full duplex ignores carrier", {15'b0, cts}, 16'h0001);
    rd_word(v); chk("R9 status with carrier", v, 16'h0003);
    rts = 0; step();
    chk("R9 follows rts low", {15'b0, cts}, 16'h0000);
    fdup = 0; carrier = 0; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sticky();
    t_setwins();
    t_frame();
    t_live();
    t_cts_half();
    t_cts_full();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule